// File: doc/BRIEF.md
# Four-Channel Host Mailbox

This block sits between an external parallel host bus and a local processor and offers four independent mailbox channels. Each channel holds one inbound byte written by the host, one outbound byte loaded by the local side, and a status byte that the host can read. The host picks a channel with its own active-low select line and moves data with active-low read and write strobes. A single address bit chooses between the data byte and the status byte on reads. On writes the same bit marks the byte as a command or as plain data, and that mark is kept in status so the local side can tell the two apart.

The host pins are asynchronous to the local clock. They pass through a two-stage synchroniser, and every host transfer takes effect when its strobe is released. The local side reaches each channel through valid/ready streams. An inbound stream offers the byte while the channel is full; `in_valid` stays high until the local side takes it, and taking it empties the channel. An outbound stream accepts a byte only while the channel's outbound register is empty. `out_ready` stays low until the host has read the previous byte, and a byte offered while `out_ready` is low waits on the local side. A level interrupt per channel follows the inbound full flag.

Top module: `host_mailbox`

## Requirements
- R1: After reset every inbound and outbound flag is clear: `irq` and `in_valid` are 0, `out_ready` is all ones, and a host status read of any channel returns 0x00.
- R2: A host write with address bit 0 to a selected channel stores the byte, sets the inbound full flag (status bit 1) and clears the command flag (status bit 3). The local side then sees `in_valid` high, the byte on `in_data`, and `in_cmd` low.
- R3: A host write with address bit 1 stores the byte as a command. It sets status bit 3 and bit 1, and `in_cmd` reads 1.
- R4: `irq[n]` is high exactly while channel n's inbound byte waits. A local handshake on `in_valid`/`in_ready` clears it.
- R5: A local handshake on `out_valid`/`out_ready` loads the outbound byte and sets the outbound full flag (status bit 0). `out_ready` of that channel stays low while the flag is set.
- R6: A host read with address bit 0 drives the outbound byte on `hd_out` with `hd_oe` high while the read strobe is low. Releasing the strobe clears the outbound full flag.
- R7: A host read with address bit 1 returns the status byte and leaves the outbound full flag unchanged.
- R8: A host strobe while a channel's select is high has no effect on that channel.
- R9: Any episode in which both strobes are low together changes no register, whichever strobe is released first.
- R10: A host write to a channel whose inbound byte is still waiting replaces the byte and keeps the flag set.
- R11: When a host write and a local take of the inbound byte land in the same cycle, the write wins: the new byte stays offered with the flag set.
- R12: Channels are independent: traffic on one channel leaves the flags and bytes of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hcs_n | input | NCH | Host channel selects, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| ha0 | input | 1 | Host address bit: 0 data, 1 command/status |
| hd_in | input | DW | Host write data |
| hd_out | output | DW | Host read data |
| hd_oe | output | 1 | High while host read data should be driven |
| in_valid | output | NCH | Inbound byte waiting, per channel |
| in_ready | input | NCH | Local side takes the inbound byte |
| in_data | output | NCH*DW | Inbound bytes, channel n at bits n*DW upward |
| in_cmd | output | NCH | Inbound byte was written as a command |
| irq | output | NCH | Inbound-full interrupt, per channel |
| out_valid | input | NCH | Local side offers an outbound byte |
| out_ready | output | NCH | Outbound register empty |
| out_data | input | NCH*DW | Outbound bytes, channel n at bits n*DW upward |

## Verification
The conflict that matters is a host write that completes in the same local cycle in which the local side takes the previous inbound byte of that channel. The bench fills a channel and then starts a second host write. It raises `in_ready` for exactly the cycle in which the synchronised write strobe's rising edge is acted upon. The scoreboard must see the old byte taken once, and afterwards `in_valid` must still be high with the new byte, which is taken in a second handshake.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  // status byte bit positions (decoded by host software)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;
endpackage

// File: rtl/hmb_sync.sv
module hmb_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hmb_host_side.sv
module hmb_host_side #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hcs_n,
  input  logic           hrd_n,
  input  logic           hwr_n,
  input  logic           ha0,
  input  logic [DW-1:0]  hd_in,
  output logic [NCH-1:0] wev,
  output logic [NCH-1:0] rev,
  output logic           wcmd,
  output logic [DW-1:0]  wdata
);
  localparam int SW = NCH + 3 + DW;

  logic [SW-1:0]  raw, s, p;
  logic [NCH-1:0] s_cs, p_cs;
  logic           s_rd, s_wr, p_rd, p_wr, p_a0;
  logic           s_a0;
  logic [DW-1:0]  s_d, p_d;
  logic           clash_q;
  logic           wr_rise, rd_rise;

  assign raw = {hcs_n, hrd_n, hwr_n, ha0, hd_in};

  hmb_sync #(.W(SW), .INIT({SW{1'b1}})) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p <= '1;
    else        p <= s;
  end

  assign {s_cs, s_rd, s_wr, s_a0, s_d} = s;
  assign {p_cs, p_rd, p_wr, p_a0, p_d} = p;

  // once both strobes are seen low, nothing counts until both are high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              clash_q <= 1'b0;
    else if (!s_rd && !s_wr) clash_q <= 1'b1;
    else if (s_rd && s_wr)   clash_q <= 1'b0;
  end

  assign wr_rise = !p_wr && s_wr && p_rd && !clash_q;
  assign rd_rise = !p_rd && s_rd && p_wr && !clash_q;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ev
      assign wev[i] = wr_rise && !p_cs[i];
      assign rev[i] = rd_rise && !p_cs[i] && !p_a0;
    end
  endgenerate

  assign wcmd  = p_a0;
  assign wdata = p_d;
endmodule

// File: rtl/hmb_chan.sv
module hmb_chan
  import hmb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wev,
  input  logic          wcmd,
  input  logic [DW-1:0] wdata,
  input  logic          rev,
  input  logic          lo_valid,
  output logic          lo_ready,
  input  logic [DW-1:0] lo_data,
  output logic          li_valid,
  input  logic          li_ready,
  output logic [DW-1:0] li_data,
  output logic          li_cmd,
  output logic [DW-1:0] odr,
  output logic [DW-1:0] status
);
  logic ibf, obf, cd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf     <= 1'b0;
      cd      <= 1'b0;
      li_data <= '0;
    end else if (wev) begin
      ibf     <= 1'b1;
      cd      <= wcmd;
      li_data <= wdata;
    end else if (li_valid && li_ready) begin
      ibf     <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obf <= 1'b0;
      odr <= '0;
    end else if (lo_valid && lo_ready) begin
      obf <= 1'b1;
      odr <= lo_data;
    end else if (rev) begin
      obf <= 1'b0;
    end
  end

  assign lo_ready = !obf;
  assign li_valid = ibf;
  assign li_cmd   = cd;

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_CMD] = cd;
  end
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hcs_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic              ha0,
  input  logic [DW-1:0]     hd_in,
  output logic [DW-1:0]     hd_out,
  output logic              hd_oe,
  output logic [NCH-1:0]    in_valid,
  input  logic [NCH-1:0]    in_ready,
  output logic [NCH*DW-1:0] in_data,
  output logic [NCH-1:0]    in_cmd,
  output logic [NCH-1:0]    irq,
  input  logic [NCH-1:0]    out_valid,
  output logic [NCH-1:0]    out_ready,
  input  logic [NCH*DW-1:0] out_data
);
  logic [NCH-1:0] wev, rev;
  logic           wcmd;
  logic [DW-1:0]  wdata;
  logic [DW-1:0]  odr_a  [NCH];
  logic [DW-1:0]  stat_a [NCH];

  hmb_host_side #(.NCH(NCH), .DW(DW)) u_host (
    .clk  (clk),
    .rst_n(rst_n),
    .hcs_n(hcs_n),
    .hrd_n(hrd_n),
    .hwr_n(hwr_n),
    .ha0  (ha0),
    .hd_in(hd_in),
    .wev  (wev),
    .rev  (rev),
    .wcmd (wcmd),
    .wdata(wdata)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      hmb_chan #(.DW(DW)) u_ch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wev     (wev[i]),
        .wcmd    (wcmd),
        .wdata   (wdata),
        .rev     (rev[i]),
        .lo_valid(out_valid[i]),
        .lo_ready(out_ready[i]),
        .lo_data (out_data[i*DW +: DW]),
        .li_valid(in_valid[i]),
        .li_ready(in_ready[i]),
        .li_data (in_data[i*DW +: DW]),
        .li_cmd  (in_cmd[i]),
        .odr     (odr_a[i]),
        .status  (stat_a[i])
      );
    end
  endgenerate

  assign irq   = in_valid;
  assign hd_oe = !hrd_n && hwr_n && (hcs_n != '1);

  // lowest selected channel drives the read bus
  always_comb begin
    hd_out = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (!hcs_n[i]) hd_out = ha0 ? stat_a[i] : odr_a[i];
    end
  end
endmodule

// File: rtl/host_mailbox_chk.sv
module host_mailbox_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hrd_n,
  input logic              hwr_n,
  input logic              hd_oe,
  input logic [NCH-1:0]    wev,
  input logic [NCH-1:0]    in_valid,
  input logic [NCH-1:0]    in_ready,
  input logic [NCH*DW-1:0] in_data,
  input logic [NCH-1:0]    out_valid,
  input logic [NCH-1:0]    out_ready
);
  // R6: read bus only enabled during a clean read strobe
  a_r6_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    hd_oe |-> (!hrd_n && hwr_n));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_a
      // R2: a completed host write leaves the channel full
      a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wev[i] |=> in_valid[i]);
      // R4: a local take without a racing write empties the channel
      a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid[i] && in_ready[i] && !wev[i]) |=> !in_valid[i]);
      // R5: an accepted outbound byte closes the outbound stream
      a_r5_load_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[i] && out_ready[i]) |=> !out_ready[i]);
      // R12: without a host write the inbound byte holds
      a_r12_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wev[i] |=> $stable(in_data[i*DW +: DW]));
    end
  endgenerate
endmodule

bind host_mailbox host_mailbox_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hrd_n    (hrd_n),
  .hwr_n    (hwr_n),
  .hd_oe    (hd_oe),
  .wev      (wev),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_valid(out_valid),
  .out_ready(out_ready)
);

// File: tb/host_mailbox_test.sv
module host_mailbox_test;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    hcs_n = '1;
  logic              hrd_n = 1'b1;
  logic              hwr_n = 1'b1;
  logic              ha0 = 1'b0;
  logic [DW-1:0]     hd_in = '0;
  logic [DW-1:0]     hd_out;
  logic              hd_oe;
  logic [NCH-1:0]    in_valid;
  logic [NCH-1:0]    in_ready = '0;
  logic [NCH*DW-1:0] in_data;
  logic [NCH-1:0]    in_cmd;
  logic [NCH-1:0]    irq;
  logic [NCH-1:0]    out_valid = '0;
  logic [NCH-1:0]    out_ready;
  logic [NCH*DW-1:0] out_data = '0;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [10:0] expq [$];   // {ch[1:0], cmd, data[7:0]}

  always #4 clk = ~clk;    // 125 MHz

  host_mailbox #(.NCH(NCH), .DW(DW)) uut (.*);

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: compare every inbound handshake against the scoreboard
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (rst_n && in_valid[c] && in_ready[c]) begin
        if (expq.size() == 0) begin
          vectors++; fails++;
          $display("FAIL R2 actual=unexpected take ch%0d expected=none", c);
        end else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk("R2/R3 scoreboard", {c[1:0], in_cmd[c], in_data[c*DW +: DW]}, e);
        end
      end
    end
  end

  task automatic hwrite(int ch, bit a0, logic [7:0] d, bit race);
    @(negedge clk);
    hcs_n = '1;
    if (ch >= 0) hcs_n[ch] = 1'b0;
    ha0 = a0; hd_in = d;
    @(negedge clk); hwr_n = 1'b0;
    repeat (3) @(negedge clk);
    hwr_n = 1'b1;
    if (race) begin
      @(posedge clk); @(posedge clk);
      #1 in_ready[ch] = 1'b1;
      @(posedge clk);
      #1 in_ready[ch] = 1'b0;
    end
    repeat (5) @(negedge clk);
    hcs_n = '1;
    @(negedge clk);
  endtask

  task automatic hread(int ch, bit a0, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hcs_n = '1; hcs_n[ch] = 1'b0; ha0 = a0;
    @(negedge clk); hrd_n = 1'b0;
    #1 d = hd_out; oe = hd_oe;
    repeat (3) @(negedge clk);
    hrd_n = 1'b1;
    repeat (5) @(negedge clk);
    hcs_n = '1;
    @(negedge clk);
  endtask

  task automatic take(int ch);
    @(posedge clk); #1 in_ready[ch] = 1'b1;
    @(posedge clk); #1 in_ready[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(int ch, logic [7:0] d);
    @(posedge clk); #1 out_valid[ch] = 1'b1; out_data[ch*DW +: DW] = d;
    @(posedge clk); #1 out_valid[ch] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 in_valid", in_valid, 0);
    chk("R1 out_ready", out_ready, 4'hF);
    hread(2, 1'b1, d, oe);
    chk("R1 status", d, 8'h00);

    // R2 data write, R4 interrupt
    expq.push_back({2'd0, 1'b0, 8'h5A});
    hwrite(0, 1'b0, 8'h5A, 1'b0);
    chk("R4 irq set", irq, 4'b0001);
    hread(0, 1'b1, d, oe);
    chk("R2 status ibf", d, 8'h02);
    chk("R12 other ch", in_valid[3:1], 0);
    take(0);
    chk("R4 irq cleared", irq, 0);

    // R3 command write
    expq.push_back({2'd2, 1'b1, 8'hD1});
    hwrite(2, 1'b1, 8'hD1, 1'b0);
    hread(2, 1'b1, d, oe);
    chk("R3 status cmd", d, 8'h0A);
    chk("R3 in_cmd", in_cmd[2], 1);
    take(2);

    // R5 / R6 / R7 outbound path
    load(1, 8'h3C);
    chk("R5 out_ready low", out_ready[1], 0);
    hread(1, 1'b1, d, oe);
    chk("R5 status obf", d, 8'h01);
    chk("R7 status keeps obf", out_ready[1], 0);
    hread(1, 1'b0, d, oe);
    chk("R6 read data", d, 8'h3C);
    chk("R6 oe", oe, 1);
    chk("R6 obf cleared", out_ready[1], 1);
    chk("R12 others ready", out_ready, 4'hF);

    // R8 no select
    hwrite(-1, 1'b0, 8'hEE, 1'b0);
    chk("R8 no select", in_valid, 0);

    // R9 both strobes low, released write first
    load(0, 8'h44);
    @(negedge clk); hcs_n = 4'b1110; ha0 = 1'b0; hd_in = 8'h77;
    @(negedge clk); hrd_n = 1'b0; hwr_n = 1'b0;
    repeat (4) @(negedge clk); hwr_n = 1'b1;
    repeat (4) @(negedge clk); hrd_n = 1'b1;
    repeat (5) @(negedge clk); hcs_n = '1;
    @(negedge clk);
    chk("R9 no inbound", in_valid[0], 0);
    chk("R9 obf kept", out_ready[0], 0);
    hread(0, 1'b0, d, oe);
    chk("R9 outbound byte", d, 8'h44);

    // R10 overwrite while full
    hwrite(3, 1'b0, 8'h11, 1'b0);
    hwrite(3, 1'b1, 8'h22, 1'b0);
    expq.push_back({2'd3, 1'b1, 8'h22});
    chk("R10 still full", in_valid[3], 1);
    take(3);

    // R11 take and write in the same cycle
    expq.push_back({2'd1, 1'b0, 8'hA1});
    hwrite(1, 1'b0, 8'hA1, 1'b0);
    expq.push_back({2'd1, 1'b0, 8'hB2});
    hwrite(1, 1'b0, 8'hB2, 1'b1);
    chk("R11 write wins", in_valid[1], 1);
    chk("R11 new byte", in_data[1*DW +: DW], 8'hB2);
    take(1);
    chk("R11 drained", in_valid, 0);
    chk("R11 queue empty", expq.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule